// File: doc/BRIEF.md
# Block and Byte Transfer Sequencer

This block moves payload between a 16-bit word FIFO and a byte-wide card data port for transfers made of one or more equal-sized blocks. Software programs a block length and a block count; each is an 11-bit field stored as field plus one. A data-transfer command flushes the FIFO, latches the direction and starts the engine. Any other command type halts it. In the read direction, bytes from the card are packed two per FIFO word, low half first. In the write direction, FIFO words are split into bytes, low half first. When a block has an odd length, its final word carries only one byte.

The remaining bytes of the current block and the remaining blocks are both visible at all times on counter outputs. At each block boundary the byte counter reloads. After the last block, both counters reload, the engine goes idle and it pulses a completion strobe. The host reaches the FIFO through a word write stream and a word read stream. The card port is a byte stream in each direction.

All streams use valid/ready. A transfer takes place on a rising clock edge where both valid and ready are high. A source that raises valid keeps it high, with its data unchanged, until it sees ready. A sink may hold ready low for any number of cycles. Because the engine owns one end of the FIFO while a transfer runs, two host paths are closed during a transfer: the host write stream in the read direction, and the host read stream in the write direction.

Top module: `xfer_sequencer`

## Requirements
- R1: After reset, both counters read 0, `busy` is low, and `crd_in_ready`, `crd_out_valid` and `xfer_done` are low.
- R2: A length write stores `(cfg_data & 0x7FF) + 1` as the block length and loads the same value into the live byte counter. For example, writing 0xF805 makes `len_cnt` read 6.
- R3: A count write stores `(cfg_data & 0x7FF) + 1` as the block count, loads that value into `blk_cnt`, and reloads `len_cnt` from the stored block length.
- R4: In the read direction, the first byte of a word goes to bits [7:0] and the second to bits [15:8]. If a block ends on a low-half byte, that word is pushed with bits [15:8] = 0x00. The FIFO never holds more than DEPTH words.
- R5: In the write direction, bits [7:0] of the head word are sent first, then bits [15:8]. If a block ends after a low byte, the head word's high byte is discarded and the word is popped.
- R6: Each byte accepted on the card port decrements `len_cnt` by one. The last byte of a block reloads `len_cnt` from the block length and decrements `blk_cnt`.
- R7: The last byte of the last block reloads both counters, drops `busy`, and raises `xfer_done` for exactly one cycle.
- R8: In the read direction, `crd_in_ready` is low whenever a new word would start while the FIFO level exceeds `af_level`. In the write direction, `crd_out_valid` is low while the FIFO is empty.
- R9: A `cmd_go` with `cmd_xfer` low stops the transfer (`busy` low on the next cycle) and leaves the counters as they were.
- R10: A `cmd_go` with `cmd_xfer` high empties the FIFO, latches `cmd_rd` as the direction (1 = card to FIFO), and raises `busy`.
- R11: The card port moves at most one byte per cycle. While `crd_out_ready` is low, `crd_out_valid` stays high and `crd_out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_we | input | 1 | Write strobe for the block length field |
| cfg_cnt_we | input | 1 | Write strobe for the block count field |
| cfg_data | input | 16 | Data for configuration writes; bits [10:0] are used |
| cmd_go | input | 1 | Command strobe |
| cmd_xfer | input | 1 | High when the command is of the data-transfer type |
| cmd_rd | input | 1 | Direction for the command: 1 = card to FIFO, 0 = FIFO to card |
| af_level | input | $clog2(DEPTH) | Almost-full threshold for read stalls |
| host_wr_valid | input | 1 | Host word write valid |
| host_wr_ready | output | 1 | Host word write ready; low when the FIFO is full or a read transfer runs |
| host_wr_data | input | 16 | Host word write data |
| host_rd_valid | output | 1 | Host word read valid; low when the FIFO is empty or a write transfer runs |
| host_rd_ready | input | 1 | Host word read ready |
| host_rd_data | output | 16 | Head word of the FIFO |
| crd_in_valid | input | 1 | Card byte valid (read direction) |
| crd_in_ready | output | 1 | Engine accepts a card byte |
| crd_in_data | input | 8 | Card byte |
| crd_out_valid | output | 1 | Byte for the card valid (write direction) |
| crd_out_ready | input | 1 | Card accepts the byte |
| crd_out_data | output | 8 | Byte for the card |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when the last block completes |
| len_cnt | output | 12 | Live remaining bytes in the current block |
| blk_cnt | output | 12 | Live remaining blocks |

## Verification
A wrong half-word phase shows up on the very next FIFO word the host pops, or the very next byte the card receives: the bytes come out swapped, or a zero pad byte appears in the wrong place. The scoreboard compares every word and every byte in order, so the first misplaced one is reported. A counter that is off by one, or that does not reload, shows up on `len_cnt` or `blk_cnt` in the cycle after the byte that caused it. It also moves `xfer_done` to the wrong byte, which leaves expected items in the queue or pops items nobody asked for. Stall and flush faults show up on `crd_in_ready` and `host_rd_valid` in the cycle after the FIFO level crosses the threshold or the command arrives.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
  localparam int FIELD_W = 11;
  localparam int CNT_W   = FIELD_W + 1;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Stored value is the programmed field plus one.
  function automatic cnt_t field_to_cnt(input word_t d);
    return cnt_t'(d[FIELD_W-1:0]) + cnt_t'(1);
  endfunction
endpackage

// File: rtl/xseq_fifo.sv
module xseq_fifo
  import xseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  word_t         push_data,
  input  logic          pop,
  output word_t         head,
  output logic [LW-1:0] level
);
  word_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic do_push, do_pop;
  assign do_push = push && (level != LW'(DEPTH));
  assign do_pop  = pop && (level != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/xseq_engine.sv
module xseq_engine
  import xseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          len_we,
  input  logic          cnt_we,
  input  word_t         cfg_data,
  input  logic          cmd_go,
  input  logic          cmd_xfer,
  input  logic          cmd_rd,
  input  logic [AW-1:0] af_level,
  input  logic [LW-1:0] fifo_level,
  input  word_t         fifo_head,
  input  logic          in_valid,
  input  byte_t         in_data,
  output logic          in_ready,
  output logic          out_valid,
  output byte_t         out_data,
  input  logic          out_ready,
  output logic          push,
  output word_t         push_data,
  output logic          pop,
  output logic          flush,
  output logic          busy,
  output logic          dir_rd,
  output cnt_t          len_cnt,
  output cnt_t          blk_cnt,
  output logic          done
);
  cnt_t  len_reg, cnt_reg;
  logic  hi_phase;
  byte_t lo_hold;

  logic beat_rd, beat_wr, beat, last_byte, room;
  assign room      = fifo_level <= LW'(af_level);
  assign in_ready  = busy && dir_rd && (hi_phase || room);
  assign out_valid = busy && !dir_rd && (fifo_level != '0);
  assign out_data  = hi_phase ? fifo_head[15:8] : fifo_head[7:0];
  assign beat_rd   = in_valid && in_ready;
  assign beat_wr   = out_valid && out_ready;
  assign beat      = beat_rd || beat_wr;
  assign last_byte = (len_cnt == cnt_t'(1));

  // A word completes on its high byte or on the final byte of a block.
  assign push      = beat_rd && (hi_phase || last_byte);
  assign push_data = hi_phase ? {in_data, lo_hold} : {8'h00, in_data};
  assign pop       = beat_wr && (hi_phase || last_byte);
  assign flush     = cmd_go && cmd_xfer;

  cnt_t new_len, new_cnt;
  assign new_len = field_to_cnt(cfg_data);
  assign new_cnt = field_to_cnt(cfg_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_reg  <= '0;
      cnt_reg  <= '0;
      len_cnt  <= '0;
      blk_cnt  <= '0;
      hi_phase <= 1'b0;
      lo_hold  <= '0;
      busy     <= 1'b0;
      dir_rd   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (beat) begin
        if (beat_rd && !hi_phase) lo_hold <= in_data;
        if (last_byte) begin
          len_cnt  <= len_reg;
          hi_phase <= 1'b0;
          if (blk_cnt == cnt_t'(1)) begin
            blk_cnt <= cnt_reg;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            blk_cnt <= blk_cnt - cnt_t'(1);
          end
        end else begin
          len_cnt  <= len_cnt - cnt_t'(1);
          hi_phase <= !hi_phase;
        end
      end
      if (cmd_go) begin
        if (cmd_xfer) begin
          busy     <= 1'b1;
          dir_rd   <= cmd_rd;
          hi_phase <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end
      if (len_we) begin
        len_reg <= new_len;
        len_cnt <= new_len;
      end
      if (cnt_we) begin
        cnt_reg <= new_cnt;
        blk_cnt <= new_cnt;
        len_cnt <= len_we ? new_len : len_reg;
      end
    end
  end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_len_we,
  input  logic              cfg_cnt_we,
  input  logic [15:0]       cfg_data,
  input  logic              cmd_go,
  input  logic              cmd_xfer,
  input  logic              cmd_rd,
  input  logic [AW-1:0]     af_level,
  input  logic              host_wr_valid,
  output logic              host_wr_ready,
  input  logic [15:0]       host_wr_data,
  output logic              host_rd_valid,
  input  logic              host_rd_ready,
  output logic [15:0]       host_rd_data,
  input  logic              crd_in_valid,
  output logic              crd_in_ready,
  input  logic [7:0]        crd_in_data,
  output logic              crd_out_valid,
  input  logic              crd_out_ready,
  output logic [7:0]        crd_out_data,
  output logic              busy,
  output logic              xfer_done,
  output logic [CNT_W-1:0]  len_cnt,
  output logic [CNT_W-1:0]  blk_cnt
);
  logic [LW-1:0] fifo_level;
  word_t         fifo_head, eng_push_data;
  logic          eng_push, eng_pop, flush, dir_rd;
  logic          host_push, host_pop;

  assign host_wr_ready = (fifo_level != LW'(DEPTH)) && !(busy && dir_rd);
  assign host_rd_valid = (fifo_level != '0) && !(busy && !dir_rd);
  assign host_rd_data  = fifo_head;
  assign host_push     = host_wr_valid && host_wr_ready;
  assign host_pop      = host_rd_valid && host_rd_ready;

  xseq_engine #(.DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .len_we(cfg_len_we), .cnt_we(cfg_cnt_we), .cfg_data(cfg_data),
    .cmd_go(cmd_go), .cmd_xfer(cmd_xfer), .cmd_rd(cmd_rd),
    .af_level(af_level), .fifo_level(fifo_level), .fifo_head(fifo_head),
    .in_valid(crd_in_valid), .in_data(crd_in_data), .in_ready(crd_in_ready),
    .out_valid(crd_out_valid), .out_data(crd_out_data), .out_ready(crd_out_ready),
    .push(eng_push), .push_data(eng_push_data), .pop(eng_pop), .flush(flush),
    .busy(busy), .dir_rd(dir_rd), .len_cnt(len_cnt), .blk_cnt(blk_cnt),
    .done(xfer_done)
  );

  xseq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(eng_push || host_push),
    .push_data(eng_push ? eng_push_data : host_wr_data),
    .pop(eng_pop || host_pop),
    .head(fifo_head), .level(fifo_level)
  );
endmodule

// File: rtl/xseq_checker.sv
module xseq_checker
  import xseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             dir_rd,
  input logic             xfer_done,
  input logic             cmd_go,
  input logic             cmd_xfer,
  input logic             cfg_len_we,
  input logic             cfg_cnt_we,
  input logic             crd_in_valid,
  input logic             crd_in_ready,
  input logic             crd_out_valid,
  input logic             crd_out_ready,
  input logic [7:0]       crd_out_data,
  input logic [LW-1:0]    fifo_level,
  input logic [CNT_W-1:0] len_cnt
);
  logic cfg_any;
  assign cfg_any = cfg_len_we || cfg_cnt_we || cmd_go;

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_len_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((crd_in_valid && crd_in_ready) || (crd_out_valid && crd_out_ready)) &&
    len_cnt > CNT_W'(1) && !cfg_any |=> len_cnt == $past(len_cnt) - CNT_W'(1));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy && $past(busy));

  p_in_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crd_in_ready |-> busy && dir_rd);

  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level == '0 |-> !crd_out_valid);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && !cmd_xfer |=> !busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    crd_out_valid && !crd_out_ready && !cmd_go |=> crd_out_valid && $stable(crd_out_data));
endmodule

bind xfer_sequencer xseq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dir_rd(dir_rd),
  .xfer_done(xfer_done), .cmd_go(cmd_go), .cmd_xfer(cmd_xfer),
  .cfg_len_we(cfg_len_we), .cfg_cnt_we(cfg_cnt_we),
  .crd_in_valid(crd_in_valid), .crd_in_ready(crd_in_ready),
  .crd_out_valid(crd_out_valid), .crd_out_ready(crd_out_ready),
  .crd_out_data(crd_out_data), .fifo_level(fifo_level), .len_cnt(len_cnt)
);

// File: tb/xfer_sequencer_tb.sv
module xfer_sequencer_tb;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_len_we = 0, cfg_cnt_we = 0, cmd_go = 0, cmd_xfer = 0, cmd_rd = 0;
  logic [15:0] cfg_data = '0;
  logic [AW-1:0] af_level = AW'(DEPTH - 1);
  logic host_wr_valid = 0, host_rd_ready = 0, crd_in_valid = 0, crd_out_ready = 0;
  logic [15:0] host_wr_data = '0;
  logic [7:0] crd_in_data = '0;
  logic host_wr_ready, host_rd_valid, crd_in_ready, crd_out_valid, busy, xfer_done;
  logic [15:0] host_rd_data;
  logic [7:0] crd_out_data;
  logic [11:0] len_cnt, blk_cnt;

  int checks = 0, errors = 0, done_seen = 0;
  logic [15:0] exp_words[$];
  logic [7:0]  exp_bytes[$];

  always #5 clk = ~clk;

  xfer_sequencer #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitors: compare popped words and sent bytes against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && host_rd_valid && host_rd_ready) begin
      if (exp_words.size() == 0) check(0, "R4 unexpected word", host_rd_data, 0);
      else begin
        logic [15:0] w;
        w = exp_words.pop_front();
        check(host_rd_data == w, "R4 word", host_rd_data, w);
      end
    end
    if (rst_n && crd_out_valid && crd_out_ready) begin
      if (exp_bytes.size() == 0) check(0, "R5 unexpected byte", crd_out_data, 0);
      else begin
        logic [7:0] b;
        b = exp_bytes.pop_front();
        check(crd_out_data == b, "R5 byte", crd_out_data, b);
      end
    end
    if (rst_n && xfer_done) done_seen++;
  end

  task automatic cfg_len(input logic [15:0] d);
    @(negedge clk); cfg_data = d; cfg_len_we = 1;
    @(negedge clk); cfg_len_we = 0;
  endtask
  task automatic cfg_cnt(input logic [15:0] d);
    @(negedge clk); cfg_data = d; cfg_cnt_we = 1;
    @(negedge clk); cfg_cnt_we = 0;
  endtask
  task automatic command(input logic x, input logic rd);
    @(negedge clk); cmd_go = 1; cmd_xfer = x; cmd_rd = rd;
    @(negedge clk); cmd_go = 0;
  endtask
  task automatic card_send(input logic [7:0] b);
    @(negedge clk); crd_in_valid = 1; crd_in_data = b;
    while (!crd_in_ready) @(negedge clk);
    @(negedge clk); crd_in_valid = 0;
  endtask
  task automatic host_push(input logic [15:0] w);
    @(negedge clk); host_wr_valid = 1; host_wr_data = w;
    while (!host_wr_ready) @(negedge clk);
    @(negedge clk); host_wr_valid = 0;
  endtask
  task automatic wait_done(input int n);
    while (done_seen < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(len_cnt == 0 && blk_cnt == 0, "R1 counters", {len_cnt, blk_cnt}, 0);
    check(!busy && !crd_in_ready && !crd_out_valid && !xfer_done, "R1 idle",
          {busy, crd_in_ready, crd_out_valid}, 0);

    // R2 masking and plus one
    cfg_len(16'hF805);
    check(len_cnt == 6, "R2 len", len_cnt, 6);
    // R3 count write reloads byte counter
    cfg_len(16'h0002);
    cfg_cnt(16'hF801);
    check(blk_cnt == 2, "R3 blk", blk_cnt, 2);
    check(len_cnt == 3, "R3 len reload", len_cnt, 3);

    // R4/R6/R7/R10: read, odd length 3, two blocks
    host_rd_ready = 1;
    exp_words.push_back(16'hB2A1); exp_words.push_back(16'h00C3);
    exp_words.push_back(16'hE5D4); exp_words.push_back(16'h00F6);
    command(1, 1);
    check(busy, "R10 busy", busy, 1);
    card_send(8'hA1);
    check(len_cnt == 2, "R6 live len", len_cnt, 2);
    card_send(8'hB2); card_send(8'hC3);
    check(len_cnt == 3 && blk_cnt == 1, "R6 block reload", {len_cnt, blk_cnt}, {12'd3, 12'd1});
    card_send(8'hD4); card_send(8'hE5); card_send(8'hF6);
    wait_done(1);
    check(!busy && done_seen == 1, "R7 done", busy, 0);
    check(len_cnt == 3 && blk_cnt == 2, "R7 reload", {len_cnt, blk_cnt}, {12'd3, 12'd2});
    check(exp_words.size() == 0, "R4 all words", exp_words.size(), 0);

    // R5/R8/R11: write, odd length 3, two blocks
    host_rd_ready = 0;
    command(1, 0);
    @(negedge clk);
    check(busy && !crd_out_valid, "R8 empty stall", crd_out_valid, 0);
    exp_bytes = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    host_push(16'h2211);
    repeat (2) @(negedge clk);
    check(crd_out_valid && crd_out_data == 8'h11, "R11 hold", crd_out_data, 8'h11);
    host_push(16'h9933); host_push(16'h5544); host_push(16'h8866);
    @(negedge clk); crd_out_ready = 1;
    wait_done(2);
    crd_out_ready = 0;
    check(exp_bytes.size() == 0, "R5 all bytes", exp_bytes.size(), 0);
    check(!busy, "R7 write done", busy, 0);

    // R8 read stall at almost-full level 1
    af_level = AW'(1);
    cfg_len(16'h0007); cfg_cnt(16'h0000);
    exp_words = '{16'h0201, 16'h0403, 16'h0605, 16'h0807};
    command(1, 1);
    card_send(8'h01); card_send(8'h02); card_send(8'h03); card_send(8'h04);
    @(negedge clk);
    check(!crd_in_ready, "R8 almost-full stall", crd_in_ready, 0);
    host_rd_ready = 1;
    card_send(8'h05); card_send(8'h06); card_send(8'h07); card_send(8'h08);
    wait_done(3);
    check(exp_words.size() == 0, "R8 words drained", exp_words.size(), 0);
    af_level = AW'(DEPTH - 1);

    // R9 non-transfer command stops
    cfg_cnt(16'h0003);
    command(1, 1);
    card_send(8'h5A);
    command(0, 0);
    check(!busy && !crd_in_ready, "R9 stopped", busy, 0);
    check(blk_cnt == 4 && len_cnt == 7, "R9 counters kept", {len_cnt, blk_cnt}, {12'd7, 12'd4});

    // R10 flush on data-transfer command
    host_rd_ready = 0;
    host_push(16'h1234); host_push(16'h5678);
    check(host_rd_valid, "R10 words present", host_rd_valid, 1);
    command(1, 1);
    check(!host_rd_valid, "R10 flushed", host_rd_valid, 0);
    command(0, 0);
    check(!host_rd_valid, "R10 still empty", host_rd_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule